// File: doc/BRIEF.md
# Converter Serial Read Port

This block is the device-side read interface of a data converter. A conversion engine, outside the block, delivers a fresh 24-bit result on a periodic load strobe. A host reads that result, or one of two other 24-bit words (a control word and a calibration word), over a three-wire serial bus. The bus has an active-low frame strobe, a serial clock and a data line that is driven only while a frame is live. An address input and a calibration-select input choose the source. An active-low ready flag tells the host that an unread result is waiting.

All bus pins are sampled in the system clock domain, so the host's serial clock must be much slower than the system clock. The block acts on the strobe's edges and on the serial clock's falling edges. At the start of a read the chosen word is copied into a private shift register, so updates to the result register cannot corrupt a word that is being sent. A read may be split across several frames. When the strobe goes high the data line is released at once and the bit position is kept. The next frame continues from that position. Back-pressure does not apply: the load strobe is always accepted, and the bus has no handshake beyond the ready flag.

Top module: `conv_serial_rdport`

## Requirements
- R1: A synchronous reset drives the ready flag high (no result waiting), turns off the data-line enable, and clears the bit position, the shift register and the result register to zero.
- R2: A load strobe writes the result register. Outside a result read it also drives the ready flag low. Repeated loads without a read keep replacing the word, so a later read returns the most recent one.
- R3: During a result read the ready flag stays low through the LSB. It returns high on the serial-clock falling edge that comes after the LSB, and the data enable turns off on that same edge.
- R4: With the address low, the control word is sent. With the address high and calibration-select low, the result register is sent. With both high, the calibration word is sent.
- R5: For a result read, word-length select high gives 24 bits and low gives 16 bits, the 16 MSBs of the result. Control and calibration reads always send 24 bits.
- R6: A frame started while the ready flag is high and the result is addressed moves no data: the enable stays off and the ready flag stays high.
- R7: The strobe's falling edge puts the MSB on the line with the enable on. Each later serial-clock falling edge presents the next bit, MSB first.
- R8: While the strobe is high the enable is off and the bit position is held. A later falling edge of the strobe resumes at the bit that was due next, for any split point.
- R9: A load during a result read does not change the word being sent. When that read completes the ready flag stays high, so the new word is lost to the host.
- R10: Control and calibration reads never change the ready flag. A load during such a read still drives it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| conv_load_i | input | 1 | One-cycle strobe: new conversion result |
| conv_word_i | input | 24 | Conversion result written on the load strobe |
| ctrl_word_i | input | 24 | Current control word |
| cal_word_i | input | 24 | Current calibration word |
| wlen24_i | input | 1 | Result word length: 1 for 24 bits, 0 for 16 bits |
| addr_i | input | 1 | Source address: 0 for control, 1 for result or calibration |
| cal_sel_i | input | 1 | With the address high, 1 selects the calibration word |
| frame_n_i | input | 1 | Frame strobe, active low |
| sclk_i | input | 1 | Serial clock from the host, idle low |
| sdata_o | output | 1 | Serial data, MSB first |
| sdata_oe_o | output | 1 | Data-line enable; the line is tri-stated when low |
| rdy_n_o | output | 1 | Ready flag, low while an unread result waits |

## Verification
Most internal faults in this block show up within one word on the data line. A wrong bit position or shift step misplaces bits in the assembled word. A wrong word-length decode moves the cycle in which the ready flag rises by eight serial-clock periods. A wrong resume position turns up only at the split point, so the bench splits a read after every possible bit. A fault in the ready-flag logic shows either as data leaking out of a blocked frame, or as the flag falling again after an overrun. Each of these appears within the frame that follows the fault.

// File: rtl/srp_pkg.sv
package srp_pkg;
  typedef enum logic [1:0] {
    SRC_OUT  = 2'd0,
    SRC_CTRL = 2'd1,
    SRC_CAL  = 2'd2
  } src_e;
endpackage

// File: rtl/srp_edge.sv
// Registers a group of synchronous pins and flags their rising and falling edges.
module srp_edge #(
  parameter int W = 1,
  parameter logic [W-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] q;

  always_ff @(posedge clk) begin
    if (rst) q <= IDLE;
    else     q <= d;
  end

  for (genvar g = 0; g < W; g++) begin : g_bit
    assign rise[g] = d[g] & ~q[g];
    assign fall[g] = ~d[g] & q[g];
  end
endmodule

// File: rtl/srp_seq.sv
// Frame sequencer: decides whether a read starts, tracks the bit position
// across split frames, and signals the end of a result read.
module srp_seq
  import srp_pkg::*;
#(
  parameter int DW = 24,
  parameter int SW = 16,
  localparam int CW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_fall,
  input  logic          frame_rise,
  input  logic          frame_n,
  input  logic          sclk_fall,
  input  logic          addr,
  input  logic          cal_sel,
  input  logic          wlen24,
  input  logic          rdy_n,
  output logic          start_o,
  output src_e          start_src_o,
  output logic          shift_o,
  output logic          active_o,
  output logic          out_busy_o,
  output logic          done_out_o
);
  localparam logic [CW-1:0] LAST_LONG  = CW'(DW - 1);
  localparam logic [CW-1:0] LAST_SHORT = CW'(SW - 1);

  logic          busy_q, active_q, wl_q;
  src_e          src_q;
  logic [CW-1:0] bitcnt_q;
  logic [CW-1:0] last_idx;
  logic          at_last, resume, finish;

  always_comb begin
    if (!addr)        start_src_o = SRC_CTRL;
    else if (cal_sel) start_src_o = SRC_CAL;
    else              start_src_o = SRC_OUT;
  end

  assign start_o  = frame_fall & ~busy_q & ((start_src_o != SRC_OUT) | ~rdy_n);
  assign resume   = frame_fall & busy_q;
  assign last_idx = (src_q == SRC_OUT && !wl_q) ? LAST_SHORT : LAST_LONG;
  assign at_last  = (bitcnt_q == last_idx);
  assign shift_o  = active_q & sclk_fall & ~at_last;
  assign finish   = active_q & sclk_fall & at_last;

  assign done_out_o = finish & (src_q == SRC_OUT);
  assign active_o   = active_q;
  assign out_busy_o = busy_q & (src_q == SRC_OUT);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      active_q <= 1'b0;
      wl_q     <= 1'b0;
      src_q    <= SRC_OUT;
      bitcnt_q <= '0;
    end else if (start_o) begin
      busy_q   <= 1'b1;
      active_q <= 1'b1;
      wl_q     <= wlen24;
      src_q    <= start_src_o;
      bitcnt_q <= '0;
    end else if (resume) begin
      active_q <= 1'b1;
    end else if (frame_rise) begin
      active_q <= 1'b0;
    end else if (finish) begin
      busy_q   <= 1'b0;
      active_q <= 1'b0;
      bitcnt_q <= '0;
    end else if (shift_o) begin
      bitcnt_q <= bitcnt_q + 1'b1;
    end
  end

  AST_BLOCKED_START: assert property (@(posedge clk) disable iff (rst)
    (frame_fall && !busy_q && addr && !cal_sel && rdy_n) |=> !active_q); // R6
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    bitcnt_q <= LAST_LONG); // R5
  AST_IDLE_WHEN_STROBE_HIGH: assert property (@(posedge clk) disable iff (rst)
    frame_n |=> !active_q); // R8
  AST_HOLD_POS_PAUSED: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !active_q && !frame_fall) |=> $stable(bitcnt_q)); // R8
endmodule

// File: rtl/srp_shift.sv
// Private copy of the word being sent, shifted MSB first.
module srp_shift #(
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_en,
  input  logic [DW-1:0] load_word,
  input  logic          shift_en,
  output logic          msb_o
);
  logic [DW-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst)           sh_q <= '0;
    else if (load_en)  sh_q <= load_word;
    else if (shift_en) sh_q <= {sh_q[DW-2:0], 1'b0};
  end

  assign msb_o = sh_q[DW-1];
endmodule

// File: rtl/srp_rdy.sv
// Result register and ready-flag control.
module srp_rdy #(
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [DW-1:0] word_i,
  input  logic          out_busy_i,
  input  logic          done_out_i,
  output logic [DW-1:0] out_reg_o,
  output logic          rdy_n_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_reg_o <= '0;
      rdy_n_o   <= 1'b1;
    end else begin
      if (load_i) out_reg_o <= word_i;
      if (done_out_i)                rdy_n_o <= 1'b1;
      else if (load_i && !out_busy_i) rdy_n_o <= 1'b0;
    end
  end

  AST_RDY_RISE_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(rdy_n_o) |-> $past(done_out_i)); // R3
  AST_RDY_FALL_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
    $fell(rdy_n_o) |-> $past(load_i)); // R2
  AST_NO_REARM_IN_READ: assert property (@(posedge clk) disable iff (rst)
    (out_busy_i && load_i && !done_out_i) |=> $stable(rdy_n_o)); // R9
endmodule

// File: rtl/conv_serial_rdport.sv
module conv_serial_rdport
  import srp_pkg::*;
#(
  parameter int DW = 24,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          conv_load_i,
  input  logic [DW-1:0] conv_word_i,
  input  logic [DW-1:0] ctrl_word_i,
  input  logic [DW-1:0] cal_word_i,
  input  logic          wlen24_i,
  input  logic          addr_i,
  input  logic          cal_sel_i,
  input  logic          frame_n_i,
  input  logic          sclk_i,
  output logic          sdata_o,
  output logic          sdata_oe_o,
  output logic          rdy_n_o
);
  logic [1:0]    rise, fall;
  logic          start, shift, active, out_busy, done_out;
  src_e          start_src;
  logic [DW-1:0] out_reg, sel_word;

  srp_edge #(.W(2), .IDLE(2'b10)) u_edge (
    .clk(clk), .rst(rst), .d({frame_n_i, sclk_i}), .rise(rise), .fall(fall)
  );

  srp_seq #(.DW(DW), .SW(SW)) u_seq (
    .clk(clk), .rst(rst),
    .frame_fall(fall[1]), .frame_rise(rise[1]), .frame_n(frame_n_i),
    .sclk_fall(fall[0]),
    .addr(addr_i), .cal_sel(cal_sel_i), .wlen24(wlen24_i), .rdy_n(rdy_n_o),
    .start_o(start), .start_src_o(start_src), .shift_o(shift),
    .active_o(active), .out_busy_o(out_busy), .done_out_o(done_out)
  );

  always_comb begin
    case (start_src)
      SRC_CTRL: sel_word = ctrl_word_i;
      SRC_CAL:  sel_word = cal_word_i;
      default:  sel_word = out_reg;
    endcase
  end

  srp_shift #(.DW(DW)) u_shift (
    .clk(clk), .rst(rst), .load_en(start), .load_word(sel_word),
    .shift_en(shift), .msb_o(sdata_o)
  );

  srp_rdy #(.DW(DW)) u_rdy (
    .clk(clk), .rst(rst), .load_i(conv_load_i), .word_i(conv_word_i),
    .out_busy_i(out_busy), .done_out_i(done_out),
    .out_reg_o(out_reg), .rdy_n_o(rdy_n_o)
  );

  assign sdata_oe_o = active;

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (rdy_n_o && !sdata_oe_o)); // R1
endmodule

// File: tb/tb_conv_serial_rdport.sv
module tb_conv_serial_rdport;
  logic        clk = 1'b0;
  logic        rst;
  logic        conv_load = 1'b0;
  logic [23:0] conv_word = '0;
  logic [23:0] ctrl_word = 24'h5A3C96;
  logic [23:0] cal_word  = 24'h81E7F0;
  logic        wlen24 = 1'b1, addr = 1'b1, cal_sel = 1'b0;
  logic        frame_n = 1'b1, sclk = 1'b0;
  logic        sdata, sdata_oe, rdy_n;
  int          nchk = 0, nerr = 0;
  logic        pre_rdy, post_rdy, post_oe;

  always #4 clk = ~clk;

  conv_serial_rdport dut (
    .clk(clk), .rst(rst), .conv_load_i(conv_load), .conv_word_i(conv_word),
    .ctrl_word_i(ctrl_word), .cal_word_i(cal_word), .wlen24_i(wlen24),
    .addr_i(addr), .cal_sel_i(cal_sel), .frame_n_i(frame_n), .sclk_i(sclk),
    .sdata_o(sdata), .sdata_oe_o(sdata_oe), .rdy_n_o(rdy_n)
  );

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic load(input logic [23:0] w);
    conv_word = w; conv_load = 1'b1; tick(); conv_load = 1'b0;
  endtask

  task automatic pulse();
    sclk = 1'b1; tick(); sclk = 1'b0; tick();
  endtask

  // Reads len bits; pauses the frame before bit 'split'; loads 'lw' before bit 'ld_at'.
  task automatic rd(input int len, input int split, input int ld_at,
                    input logic [23:0] lw, output logic [23:0] got);
    got = '0;
    frame_n = 1'b0; tick();
    chk("R7 enable on at frame start", sdata_oe, 1);
    for (int i = 0; i < len; i++) begin
      if (i == split && i > 0) begin
        frame_n = 1'b1; tick();
        chk("R8 enable off while paused", sdata_oe, 0);
        frame_n = 1'b0; tick();
      end
      if (i == ld_at) load(lw);
      got = {got[22:0], sdata};
      if (i == len - 1) pre_rdy = rdy_n;
      pulse();
    end
    post_rdy = rdy_n;
    post_oe  = sdata_oe;
    frame_n = 1'b1; tick();
  endtask

  task automatic blocked(input string rq);
    frame_n = 1'b0; tick();
    chk(rq, sdata_oe, 0);
    pulse(); pulse();
    chk(rq, {sdata_oe, rdy_n}, 2'b01);
    frame_n = 1'b1; tick();
  endtask

  initial begin
    logic [23:0] got, w;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tick();
    chk("R1 ready flag after reset", rdy_n, 1);
    chk("R1 enable after reset", sdata_oe, 0);

    blocked("R6 blocked frame after reset");
    // R1: result register cleared, so a 24-bit read after a zero load-less arm is impossible; arm with zero word
    load(24'h000000);
    rd(24, -1, -1, '0, got);
    chk("R1 cleared result read back", got, 24'h000000);

    load(24'h123456);
    chk("R2 ready low after load", rdy_n, 0);
    load(24'hFEDCBA);
    rd(24, -1, -1, '0, got);
    chk("R2 latest word returned", got, 24'hFEDCBA);
    chk("R3 ready low through LSB", pre_rdy, 0);
    chk("R3 ready high after final edge", post_rdy, 1);
    chk("R3 enable off after final edge", post_oe, 0);
    blocked("R6 blocked after completed read");

    addr = 1'b0;
    rd(24, -1, -1, '0, got);
    chk("R4 control word", got, ctrl_word);
    chk("R10 control read leaves flag high", post_rdy, 1);
    addr = 1'b1; cal_sel = 1'b1; wlen24 = 1'b0;
    rd(24, -1, -1, '0, got);
    chk("R4 R5 calibration word 24 bits at short length", got, cal_word);
    chk("R10 calibration read leaves flag high", post_rdy, 1);
    cal_sel = 1'b0;

    load(24'hA1B2C3);
    rd(16, -1, -1, '0, got);
    chk("R5 short read sends 16 MSBs", got, 24'h00A1B2);
    chk("R5 R3 short read flag low through bit 16", pre_rdy, 0);
    chk("R5 R3 short read flag high after bit 16", post_rdy, 1);
    wlen24 = 1'b1;

    for (int p = 1; p < 24; p++) begin
      w = 24'((p * 24'h13579B) ^ 24'hC0FFEE);
      load(w);
      rd(24, p, -1, '0, got);
      chk("R8 split read word", got, w);
      chk("R8 flag high after split read", post_rdy, 1);
    end

    load(24'h0F0F0F);
    rd(24, -1, 10, 24'h777777, got);
    chk("R9 word unchanged by mid-read load", got, 24'h0F0F0F);
    chk("R9 flag stays high after overrun", post_rdy, 1);
    blocked("R9 R6 overrun word not offered");
    load(24'h3C3C3C);
    rd(24, -1, -1, '0, got);
    chk("R2 next load readable", got, 24'h3C3C3C);

    load(24'h9A9A9A);
    addr = 1'b0;
    rd(24, -1, -1, '0, got);
    chk("R10 control read with flag low", got, ctrl_word);
    chk("R10 flag still low after control read", post_rdy, 0);
    addr = 1'b1;
    rd(24, -1, -1, '0, got);
    chk("R10 result intact after control read", got, 24'h9A9A9A);

    addr = 1'b0; cal_sel = 1'b1;
    rd(24, -1, 5, 24'h246801, got);
    chk("R10 control data during load", got, ctrl_word);
    chk("R10 load during control read lowers flag", post_rdy, 0);
    addr = 1'b1; cal_sel = 1'b0;
    rd(24, 12, -1, '0, got);
    chk("R10 R8 result after load in control read", got, 24'h246801);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end
endmodule